// File: doc/BRIEF.md
# Synchronous burst memory cycle decoder

This block samples the control inputs of a synchronous burst SRAM on every rising clock edge. It works out what kind of cycle they request and carries that cycle out on a word array held inside the block. The data word is split into byte lanes, four of eight bits by default. The inputs are three chip enables, a processor-side and a controller-side address strobe, a burst advance input, a global write, a byte-write enable and one enable per lane.

Each cycle is one of five kinds: a deselect, a burst start that reads, a burst start that writes, a continue at the next burst address, or a suspend at the current burst address. For a write, the block builds a lane mask and updates only the selected lanes of the addressed word. For a read, it registers the addressed word onto the read data output. The operation, the cycle class and the write mask are registered and presented to a downstream output stage.

Top module: `sburst_cycle_dec`

## Requirements
- R1: A deselect cycle reports op 0 and class 0 and leaves the array unchanged. It occurs in three cases: primary enable (active low) high with the controller strobe low; primary enable low, secondary condition false and processor strobe low; primary enable low, secondary condition false, processor strobe high and controller strobe low. The secondary condition is true only when the active-high enable is 1 and the second active-low enable is 0.
- R2: With the primary enable low, the secondary condition true and the processor strobe low, a burst read begins at the external address, whatever the write inputs are. The write mask is 0 and the array is not written.
- R3: With the primary enable low, the secondary condition true, the processor strobe high and the controller strobe low, a burst begins at the external address. It is a write when the write condition holds and a read otherwise.
- R4: When no strobe is accepted, a low advance input continues and a high advance input suspends. No strobe is accepted when both strobes are high, or when the controller strobe is high and the primary enable is high. Continue moves to the next address: the low two address bits are incremented modulo 4 and the upper bits are held. Suspend stays at the current address. Whether the cycle reads or writes follows the write condition.
- R5: The secondary enables are ignored in cycles where no strobe is accepted.
- R6: A low global write gives write mask 4'b1111, whatever the byte-write enable and lane enables are.
- R7: With global write high and byte-write enable low, mask bit i is the inverse of lane enable i, and lane i is data bits [8i+7:8i]. The cycle is a read, with mask 0, when the byte-write enable is high or all lane enables are high.
- R8: A write changes only the enabled lanes of the addressed word. Other lanes keep their contents.
- R9: op_o (0 deselect, 1 read, 2 write), cls_o (0 none, 1 begin, 2 continue, 3 suspend) and wmask_o are registered at the sampling edge. After a read edge, rdata_o holds the word at the cycle's address. It keeps its value in all other cycles.
- R10: While reset is asserted, op_o, cls_o, wmask_o and rdata_o are 0 and the burst address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Secondary chip enable, active low |
| strb_proc_ni | input | 1 | Processor-side address strobe, active low |
| strb_ctrl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| lane_en_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data |
| op_o | output | 2 | Registered operation code |
| cls_o | output | 2 | Registered cycle class |
| wmask_o | output | LANES | Registered write lane mask |
| rdata_o | output | LANES*LANE_W | Registered read word |

## Verification
The bench builds the block with ADDR_W=4, a 16-word array, and keeps the default four eight-bit lanes. With this size, addresses whose upper bits are nonzero can be used. A continue from word 7 is therefore seen to wrap to word 4 rather than to word 0 or 8, and a continued write from word 8 lands in word 9. The small array also lets each word written be read back directly through a processor-strobe read.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    OP_DSEL = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_BEGIN = 2'd1,
    CLS_CONT  = 2'd2,
    CLS_SUSP  = 2'd3
  } cls_e;
endpackage

// File: rtl/sbc_wmask.sv
module sbc_wmask #(
  parameter int LANES = 4
) (
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] lane_en_ni,
  output logic [LANES-1:0] mask_o,
  output logic             wr_o
);
  always_comb begin
    if (!gw_ni)       mask_o = '1;
    else if (!bwe_ni) mask_o = ~lane_en_ni;
    else              mask_o = '0;
  end

  assign wr_o = |mask_o;
endmodule

// File: rtl/sbc_classify.sv
module sbc_classify
  import sbc_pkg::*;
(
  input  logic ce1_ni,
  input  logic sec_ok_i,
  input  logic strb_proc_ni,
  input  logic strb_ctrl_ni,
  input  logic adv_ni,
  input  logic wr_i,
  output op_e  op_o,
  output cls_e cls_o
);
  always_comb begin
    if (!ce1_ni && !strb_proc_ni) begin
      // processor strobe: always a read start
      op_o  = sec_ok_i ? OP_RD : OP_DSEL;
      cls_o = sec_ok_i ? CLS_BEGIN : CLS_NONE;
    end else if (!strb_ctrl_ni) begin
      if (!ce1_ni && sec_ok_i) begin
        op_o  = wr_i ? OP_WR : OP_RD;
        cls_o = CLS_BEGIN;
      end else begin
        op_o  = OP_DSEL;
        cls_o = CLS_NONE;
      end
    end else begin
      // no strobe accepted; secondary enables not looked at
      op_o  = wr_i ? OP_WR : OP_RD;
      cls_o = adv_ni ? CLS_SUSP : CLS_CONT;
    end
  end
endmodule

// File: rtl/sbc_store.sv
module sbc_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wr_en_i && mask_i[l])
        mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[addr_i];
  end

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/sburst_cycle_dec.sv
module sburst_cycle_dec
  import sbc_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    strb_proc_ni,
  input  logic                    strb_ctrl_ni,
  input  logic                    adv_ni,
  input  logic                    gw_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        lane_en_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [1:0]              op_o,
  output logic [1:0]              cls_o,
  output logic [LANES-1:0]        wmask_o,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  logic              sec_ok;
  logic [LANES-1:0]  mask_raw, mask_eff;
  logic              wr_cond;
  op_e               op_d;
  cls_e              cls_d;
  logic [ADDR_W-1:0] addr_q, addr_nxt, addr_eff;

  assign sec_ok = ce2_i && !ce3_ni;

  sbc_wmask #(.LANES(LANES)) u_wmask (
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .lane_en_ni (lane_en_ni),
    .mask_o     (mask_raw),
    .wr_o       (wr_cond)
  );

  sbc_classify u_cls (
    .ce1_ni       (ce1_ni),
    .sec_ok_i     (sec_ok),
    .strb_proc_ni (strb_proc_ni),
    .strb_ctrl_ni (strb_ctrl_ni),
    .adv_ni       (adv_ni),
    .wr_i         (wr_cond),
    .op_o         (op_d),
    .cls_o        (cls_d)
  );

  always_comb begin
    addr_nxt = addr_q;
    addr_nxt[BURST_W-1:0] = addr_q[BURST_W-1:0] + 1'b1;
    unique case (cls_d)
      CLS_BEGIN: addr_eff = addr_i;
      CLS_CONT:  addr_eff = addr_nxt;
      default:   addr_eff = addr_q;
    endcase
  end

  assign mask_eff = (op_d == OP_WR) ? mask_raw : '0;

  sbc_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (op_d == OP_WR),
    .rd_en_i (op_d == OP_RD),
    .addr_i  (addr_eff),
    .mask_i  (mask_eff),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      op_o    <= OP_DSEL;
      cls_o   <= CLS_NONE;
      wmask_o <= '0;
    end else begin
      addr_q  <= addr_eff;
      op_o    <= op_d;
      cls_o   <= cls_d;
      wmask_o <= mask_eff;
    end
  end

  p_dsel_sec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && !strb_proc_ni && !(ce2_i && !ce3_ni)) |=> (op_o == OP_DSEL && wmask_o == '0));
  p_proc_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && !strb_proc_ni && ce2_i && !ce3_ni) |=> (op_o == OP_RD && cls_o == CLS_BEGIN && wmask_o == '0));
  p_susp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == CLS_SUSP) |-> $stable(addr_q));
  p_gw_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_ni && strb_proc_ni && !strb_ctrl_ni && !ce1_ni && ce2_i && !ce3_ni) |=> (wmask_o == '1));
  p_rd_nomask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o != OP_WR) |-> (wmask_o == '0));
endmodule

// File: tb/sburst_cycle_dec_tb_top.sv
`timescale 1ns/1ps
module sburst_cycle_dec_tb_top;
  localparam int AW = 4;
  localparam int LN = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1, ce2 = 1, ce3_n = 0, sp_n = 1, sc_n = 0, adv_n = 1, gw_n = 1, bwe_n = 1;
  logic [LN-1:0] be_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] op, cls;
  logic [LN-1:0] wmask;
  logic [DW-1:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sburst_cycle_dec #(.ADDR_W(AW), .LANES(LN), .LANE_W(8), .BURST_W(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .strb_proc_ni(sp_n), .strb_ctrl_ni(sc_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .lane_en_ni(be_n), .addr_i(addr), .wdata_i(wdata),
    .op_o(op), .cls_o(cls), .wmask_o(wmask), .rdata_o(rdata)
  );

  // ctl = {ce1_n, ce2, ce3_n, sp_n, sc_n, adv_n, gw_n, bwe_n, be_n[3:0]}
  localparam logic [11:0] C_PRD     = 12'b0_1_0_0_1_1_1_1_1111;
  localparam logic [11:0] C_PRD_GW  = 12'b0_1_0_0_1_1_0_1_1111;
  localparam logic [11:0] C_CWR_GW  = 12'b0_1_0_1_0_1_0_1_1111;
  localparam logic [11:0] C_CWR_B0  = 12'b0_1_0_1_0_1_1_0_1110;
  localparam logic [11:0] C_CONT_RD = 12'b1_1_0_1_1_0_1_1_1111;
  localparam logic [11:0] C_SUSP_RD = 12'b1_1_0_1_1_1_1_1_1111;
  localparam logic [11:0] C_CONT_WR = 12'b1_1_0_1_1_0_0_1_1111;
  localparam logic [11:0] C_DSEL_GW = 12'b1_1_0_1_0_1_0_1_1111;

  // {ctl[11:0], exp op[1:0], exp cls[1:0], exp mask[3:0]}
  localparam logic [19:0] VEC [12] = '{
    20'b1_1_0_1_0_1_1_1_1111_00_00_0000, // R1 ce1 high, ctrl strobe
    20'b0_0_0_0_1_1_1_1_1111_00_00_0000, // R1 sec false, proc strobe
    20'b0_1_1_1_0_1_1_1_1111_00_00_0000, // R1 sec false, ctrl strobe
    20'b0_1_0_0_1_1_0_1_1111_01_01_0000, // R2 proc start ignores gw
    20'b0_1_0_1_0_1_1_0_1010_10_01_0101, // R7 lanes 0 and 2
    20'b0_1_0_1_0_1_1_1_0000_01_01_0000, // R7 bwe high -> read
    20'b0_1_0_1_0_1_1_0_1111_01_01_0000, // R7 no lanes -> read
    20'b1_0_1_1_1_0_1_1_1111_01_10_0000, // R5 continue, sec false ignored
    20'b1_1_0_0_1_1_0_1_1111_10_11_1111, // R4 proc masked by ce1, suspend write
    20'b0_1_0_1_1_0_1_0_0000_10_10_1111, // R4 continue write
    20'b0_1_0_1_0_1_0_1_1111_10_01_1111, // R6 gw low all lanes
    20'b0_1_0_1_0_1_1_0_0111_10_01_1000  // R3 ctrl start write lane 3
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    {ce1_n, ce2, ce3_n, sp_n, sc_n, adv_n, gw_n, bwe_n, be_n} = c;
    addr = a;
    wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1;
    chk("R10 op", 32'(op), 0);
    chk("R10 cls", 32'(cls), 0);
    chk("R10 mask", 32'(wmask), 0);
    chk("R10 rdata", rdata, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][19:8], '0, 32'h0);
      chk($sformatf("R9 vec%0d op", i), 32'(op), 32'(VEC[i][7:6]));
      chk($sformatf("R9 vec%0d cls", i), 32'(cls), 32'(VEC[i][5:4]));
      chk($sformatf("R7 vec%0d mask", i), 32'(wmask), 32'(VEC[i][3:0]));
    end

    // R8 partial lane write
    cyc(C_CWR_GW, 4'd3, 32'hAABBCCDD);
    cyc(C_CWR_B0, 4'd3, 32'h11223344);
    cyc(C_PRD, 4'd3, 32'h0);
    chk("R8 lane0 only", rdata, 32'hAABBCC44);

    // R3/R4 burst continue, suspend, wrap
    cyc(C_CWR_GW, 4'd4, 32'h44440004);
    cyc(C_CWR_GW, 4'd5, 32'h55550005);
    cyc(C_CWR_GW, 4'd7, 32'h77770007);
    cyc(C_PRD, 4'd4, 32'h0);
    chk("R2 read at ext addr", rdata, 32'h44440004);
    cyc(C_CONT_RD, 4'd0, 32'h0);
    chk("R4 continue next", rdata, 32'h55550005);
    cyc(C_SUSP_RD, 4'd0, 32'h0);
    chk("R4 suspend same", rdata, 32'h55550005);
    chk("R4 suspend cls", 32'(cls), 3);
    cyc(C_PRD, 4'd7, 32'h0);
    cyc(C_CONT_RD, 4'd0, 32'h0);
    chk("R4 wrap 7 to 4", rdata, 32'h44440004);

    // R1 deselect writes nothing, rdata holds
    cyc(C_DSEL_GW, 4'd4, 32'hDEADBEEF);
    chk("R1 dsel op", 32'(op), 0);
    chk("R9 rdata hold", rdata, 32'h44440004);
    cyc(C_PRD, 4'd4, 32'h0);
    chk("R1 no write", rdata, 32'h44440004);

    // R2 proc start with gw low does not write
    cyc(C_PRD_GW, 4'd5, 32'hBADBAD00);
    chk("R2 op read", 32'(op), 1);
    chk("R2 data", rdata, 32'h55550005);
    cyc(C_PRD, 4'd5, 32'h0);
    chk("R2 not written", rdata, 32'h55550005);

    // R4 continued write
    cyc(C_CWR_GW, 4'd8, 32'h00000088);
    cyc(C_CONT_WR, 4'd0, 32'h00000099);
    cyc(C_PRD, 4'd9, 32'h0);
    chk("R4 cont write addr9", rdata, 32'h00000099);
    cyc(C_PRD, 4'd8, 32'h0);
    chk("R3 begin write addr8", rdata, 32'h00000088);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule